// File: doc/BRIEF.md
# Clock Output Conditioner with Combined Lock Status

This block sits behind two synthesized clock sources. It turns each one into a pad-ready output. Each channel can pass its source clock through unchanged, or it can pass a divide-by-eight copy with a 50% duty cycle. Each channel also has its own output enable. When that enable is clear, the pad driver is released, and the data the block presents for that pad is held low. The two source clocks and the two per-source lock flags arrive asynchronously. The block samples them with a fast system clock, `clk`, through synchronizer chains.

A single status output reports lock for the set of sources that are currently enabled. A source whose enable bit is clear has no say in the result. When no source is enabled, the status reads unlocked. Control arrives as two single enable bits, one for each source. It also arrives as a four-bit output-control word whose bit positions are fixed by the register decoder next to this block. After reset every output enable is off, every clock output is low and the lock status is low.

Top module: `clk_out_ctl`

## Requirements
- R1: While reset is held, and on the first cycles after it, `clk_oe` is 2'b00, `clk_out` is 2'b00 and `lock_det` is 0, whatever the source clocks and lock flags are doing.
- R2: With its divide bit at 0, a channel output repeats its source clock. It has the same period and the same high time, measured in `clk` cycles, and it lags the source by a fixed number of cycles.
- R3: With its divide bit at 1, a channel output has a period of eight source periods. Its high time is exactly four source periods.
- R4: In `out_ctl`, bit 0 is the divide select of channel 0 (`clk_out[0]`) and bit 1 is the divide select of channel 1 (`clk_out[1]`). The two channels are configured independently.
- R5: In `out_ctl`, bit 3 drives `clk_oe[0]` and bit 2 drives `clk_oe[1]`, one `clk` cycle later. While a channel's enable is 0, its `clk_out` bit stays 0.
- R6: A change of a divide select takes effect only at a falling edge of that channel's divided clock. The change never produces a high or low output pulse shorter than one source half-period.
- R7: With both sources enabled (`pll_en` = 2'b11), `lock_det` is 1 only while both lock flags are 1. It returns to 0 within five `clk` cycles after either flag drops.
- R8: With exactly one source enabled, `lock_det` follows that source's lock flag alone. The lock flag of the disabled source has no effect.
- R9: With `pll_en` = 2'b00, `lock_det` is 0 for every combination of lock flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, much faster than either source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_clk | input | 2 | Source clocks from the two synthesizers (bit 0 = channel 0) |
| pll_lock | input | 2 | Asynchronous lock flags of the two synthesizers |
| pll_en | input | 2 | Per-synthesizer enable bits (bit 0 = first synthesizer) |
| out_ctl | input | 4 | Output-control word: [0] div ch0, [1] div ch1, [2] enable ch1, [3] enable ch0 |
| clk_out | output | 2 | Conditioned clock data for the two pads |
| clk_oe | output | 2 | Pad drive enables; 0 releases the pad |
| lock_det | output | 1 | Combined lock status of the enabled synthesizers |

## Verification
The assertions rely on the control word and the enable bits already being synchronous to `clk`. They also rely on each source clock holding every level for at least two `clk` cycles, so that the synchronizer sees every edge. The stimulus changes all control inputs only at falling edges of `clk`. It produces the source clocks with half-periods drawn from $urandom between two and five cycles, so edges are never lost. Measured periods, high times and minimum pulse widths are compared against values that bench functions compute from the chosen half-periods and divide settings. Lock cases cover every combination of enable and lock flag, first in a directed pass and then in a random pass.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   // number of conditioned clock channels
   localparam int unsigned CH_COUNT = 2;
   // width of the output-control word
   localparam int unsigned CTL_W    = 4;

   typedef struct packed {
      logic div;   // divided output selected
      logic oe;    // pad drive enabled
   } chan_cfg_t;

   // divide selects sit at the low bits in channel order
   function automatic int unsigned div_pos(input int unsigned ch);
      return ch;
   endfunction

   // enables sit at the high bits in reverse channel order
   function automatic int unsigned oe_pos(input int unsigned ch);
      return (CTL_W - 1) - ch;
   endfunction

   function automatic chan_cfg_t decode_cfg(input logic [CTL_W-1:0] w,
                                            input int unsigned ch);
      chan_cfg_t c;
      c.div = w[div_pos(ch)];
      c.oe  = w[oe_pos(ch)];
      return c;
   endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      assert (WIDTH >= 1) else $error("bit_sync: WIDTH must be at least 1");
      assert (STAGES >= 1) else $error("bit_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= '0;
         else        stg <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= '0;
         else        stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/clk_div_chan.sv
module clk_div_chan #(
   parameter int unsigned DIV_LOG2    = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic div_req,
   input  logic oe_req,
   output logic clk_o,
   output logic oe_o
);

   initial begin
      assert (DIV_LOG2 >= 1) else $error("clk_div_chan: DIV_LOG2 must be at least 1");
   end

   logic s;       // synchronized source level
   logic s_d;     // one cycle older
   logic rise;    // source rising edge seen this cycle
   logic wrap;    // half of a divided period completes
   logic div_q;   // divided clock
   logic mode_q;  // active selection: 1 = divided
   logic out_q;
   logic oe_q;

   bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src),
      .q     (s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_d <= 1'b0;
      else        s_d <= s;
   end

   assign rise = s & ~s_d;

   if (DIV_LOG2 == 1) begin : g_half1
      assign wrap = rise;
   end else begin : g_cnt
      localparam int unsigned CW = DIV_LOG2 - 1;
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt <= '0;
         else if (rise) cnt <= cnt + CW'(1);
      end
      assign wrap = rise & (&cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= 1'b0;
      else if (wrap) div_q <= ~div_q;
   end

   // selection moves only where the divided clock falls
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             mode_q <= 1'b0;
      else if (wrap && div_q) mode_q <= div_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         out_q <= mode_q ? div_q : s_d;
         oe_q  <= oe_req;
      end
   end

   assign clk_o = out_q & oe_q;
   assign oe_o  = oe_q;

   // R6
   mode_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q)) |-> ($past(div_q) && !div_q));

   // R3
   div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q != $past(div_q)) |-> $rose(s_d));

endmodule

// File: rtl/lock_combine.sv
module lock_combine #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] en,
   input  logic [N-1:0] lock_s,
   output logic         lock_det
);

   logic any_en;
   logic all_ok;

   assign any_en = |en;
   assign all_ok = &(lock_s | ~en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_det <= 1'b0;
      else        lock_det <= any_en & all_ok;
   end

   // R9
   lock_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_det |-> $past(|en));

   // R7
   lock_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_det |-> (&($past(lock_s) | ~$past(en))));

endmodule

// File: rtl/clk_out_ctl.sv
module clk_out_ctl
   import clkctl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DIV_LOG2    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CH_COUNT-1:0] pll_clk,
   input  logic [CH_COUNT-1:0] pll_lock,
   input  logic [CH_COUNT-1:0] pll_en,
   input  logic [CTL_W-1:0]    out_ctl,
   output logic [CH_COUNT-1:0] clk_out,
   output logic [CH_COUNT-1:0] clk_oe,
   output logic                lock_det
);

   logic [CH_COUNT-1:0] lock_s;

   bit_sync #(.WIDTH(CH_COUNT), .STAGES(SYNC_STAGES)) u_lock_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pll_lock),
      .q     (lock_s)
   );

   lock_combine #(.N(CH_COUNT)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (pll_en),
      .lock_s   (lock_s),
      .lock_det (lock_det)
   );

   for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
      chan_cfg_t cfg;
      assign cfg = decode_cfg(out_ctl, g);

      clk_div_chan #(.DIV_LOG2(DIV_LOG2), .SYNC_STAGES(SYNC_STAGES)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .src     (pll_clk[g]),
         .div_req (cfg.div),
         .oe_req  (cfg.oe),
         .clk_o   (clk_out[g]),
         .oe_o    (clk_oe[g])
      );

      // R5
      oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (clk_oe[g] == $past(out_ctl[oe_pos(g)])));
   end

endmodule

// File: tb/sim_clk_out_ctl.sv
module sim_clk_out_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       src0 = 1'b0, src1 = 1'b0;
   logic [1:0] pll_lock = 2'b00;
   logic [1:0] pll_en = 2'b00;
   logic [3:0] out_ctl = 4'b0000;
   logic [1:0] clk_out, clk_oe;
   logic       lock_det;
   logic       clr = 1'b0;
   int         hp0 = 3, hp1 = 4;
   int         checks = 0, fails = 0;

   clk_out_ctl u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .pll_clk  ({src1, src0}),
      .pll_lock (pll_lock),
      .pll_en   (pll_en),
      .out_ctl  (out_ctl),
      .clk_out  (clk_out),
      .clk_oe   (clk_oe),
      .lock_det (lock_det)
   );

   always #5 clk = ~clk;

   initial forever begin
      repeat (hp0) @(negedge clk);
      src0 = ~src0;
   end
   initial forever begin
      repeat (hp1) @(negedge clk);
      src1 = ~src1;
   end

   // pulse measurement per channel
   for (genvar g = 0; g < 2; g++) begin : g_mon
      int cyc = 0, t_rise = -1, t_fall = -1, nrise = 0;
      int pmin = 1000000, pmax = 0, hmin = 1000000, hmax = 0, wmin = 1000000;
      logic prev = 1'b0;
      always @(negedge clk) begin
         cyc++;
         if (clr) begin
            t_rise = -1; t_fall = -1; nrise = 0;
            pmin = 1000000; pmax = 0; hmin = 1000000; hmax = 0; wmin = 1000000;
         end else if (clk_out[g] && !prev) begin
            if (t_rise >= 0) begin
               if (cyc - t_rise < pmin) pmin = cyc - t_rise;
               if (cyc - t_rise > pmax) pmax = cyc - t_rise;
            end
            if (t_fall >= 0 && cyc - t_fall < wmin) wmin = cyc - t_fall;
            t_rise = cyc;
            nrise++;
         end else if (!clk_out[g] && prev) begin
            if (t_rise >= 0) begin
               if (cyc - t_rise < hmin) hmin = cyc - t_rise;
               if (cyc - t_rise > hmax) hmax = cyc - t_rise;
               if (cyc - t_rise < wmin) wmin = cyc - t_rise;
            end
            t_fall = cyc;
         end
         prev = clk_out[g];
      end
   end

   function automatic int exp_period(input int hp, input logic div);
      return div ? 16 * hp : 2 * hp;
   endfunction

   function automatic int exp_high(input int hp, input logic div);
      return div ? 8 * hp : hp;
   endfunction

   function automatic logic exp_lock(input logic [1:0] en, input logic [1:0] lk);
      return (en != 2'b00) && ((lk | ~en) == 2'b11);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_ge(input string req, input int act, input int lim);
      checks++;
      if (act < lim) begin
         fails++;
         $display("FAIL %s: actual %0d expected >= %0d", req, act, lim);
      end
   endtask

   task automatic lock_case(input logic [1:0] en, input logic [1:0] lk, input string req);
      @(negedge clk);
      pll_en = en;
      pll_lock = lk;
      repeat (6) @(negedge clk);
      chk(req, int'(lock_det), int'(exp_lock(en, lk)));
   endtask

   task automatic pulse_clr();
      @(posedge clk);
      clr = 1'b1;
      @(posedge clk);
      clr = 1'b0;
   endtask

   task automatic run_shape(input logic [1:0] divs, input logic [1:0] oes);
      @(negedge clk);
      out_ctl = {oes[0], oes[1], divs[1], divs[0]};
      repeat (250) @(negedge clk);
      pulse_clr();
      repeat (500) @(negedge clk);
      if (oes[0]) begin
         chk("R2/R3/R4 ch0 period min", g_mon[0].pmin, exp_period(hp0, divs[0]));
         chk("R2/R3/R4 ch0 period max", g_mon[0].pmax, exp_period(hp0, divs[0]));
         chk("R2/R3 ch0 high min", g_mon[0].hmin, exp_high(hp0, divs[0]));
         chk("R2/R3 ch0 high max", g_mon[0].hmax, exp_high(hp0, divs[0]));
      end else begin
         chk("R5 ch0 no edges while disabled", g_mon[0].nrise, 0);
         chk("R5 ch0 oe low", int'(clk_oe[0]), 0);
      end
      if (oes[1]) begin
         chk("R2/R3/R4 ch1 period min", g_mon[1].pmin, exp_period(hp1, divs[1]));
         chk("R2/R3/R4 ch1 period max", g_mon[1].pmax, exp_period(hp1, divs[1]));
         chk("R2/R3 ch1 high min", g_mon[1].hmin, exp_high(hp1, divs[1]));
         chk("R2/R3 ch1 high max", g_mon[1].hmax, exp_high(hp1, divs[1]));
      end else begin
         chk("R5 ch1 no edges while disabled", g_mon[1].nrise, 0);
         chk("R5 ch1 oe low", int'(clk_oe[1]), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      pll_lock = 2'b11;
      repeat (5) @(negedge clk);
      chk("R1 oe in reset", int'(clk_oe), 0);
      chk("R1 out in reset", int'(clk_out), 0);
      chk("R1 lock in reset", int'(lock_det), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 oe after reset", int'(clk_oe), 0);
      chk("R1 out after reset", int'(clk_out), 0);
      chk("R1 lock after reset", int'(lock_det), 0);

      // directed lock cases
      lock_case(2'b00, 2'b11, "R9 none enabled both locked");
      lock_case(2'b00, 2'b00, "R9 none enabled none locked");
      lock_case(2'b11, 2'b11, "R7 both enabled both locked");
      lock_case(2'b11, 2'b01, "R7 both enabled one lost");
      lock_case(2'b11, 2'b10, "R7 both enabled other lost");
      lock_case(2'b01, 2'b01, "R8 first only, other unlocked ignored");
      lock_case(2'b01, 2'b10, "R8 first only, unlocked");
      lock_case(2'b10, 2'b10, "R8 second only, other unlocked ignored");
      lock_case(2'b10, 2'b01, "R8 second only, unlocked");
      for (int i = 0; i < 20; i++) begin
         logic [1:0] en, lk;
         en = 2'($urandom % 4);
         lk = 2'($urandom % 4);
         lock_case(en, lk, (en == 2'b00) ? "R9 random" : (en == 2'b11) ? "R7 random" : "R8 random");
      end

      // enable latency, R5
      @(negedge clk);
      out_ctl = 4'b1000;
      @(negedge clk);
      chk("R5 bit3 drives clk_oe[0] after one cycle", int'(clk_oe), 1);
      out_ctl = 4'b0100;
      @(negedge clk);
      chk("R5 bit2 drives clk_oe[1] after one cycle", int'(clk_oe), 2);

      // directed shapes
      run_shape(2'b00, 2'b11);
      run_shape(2'b11, 2'b11);
      run_shape(2'b01, 2'b11);
      run_shape(2'b10, 2'b11);
      run_shape(2'b11, 2'b00);
      // random shapes
      for (int i = 0; i < 8; i++) begin
         hp0 = 2 + int'($urandom % 4);
         hp1 = 2 + int'($urandom % 4);
         run_shape(2'($urandom % 4), 2'($urandom % 4));
      end

      // R6: random switching must not shorten any pulse
      hp0 = 2 + int'($urandom % 4);
      hp1 = 2 + int'($urandom % 4);
      @(negedge clk);
      out_ctl = 4'b1100;
      repeat (250) @(negedge clk);
      pulse_clr();
      for (int i = 0; i < 24; i++) begin
         repeat (1 + int'($urandom % 60)) @(negedge clk);
         out_ctl[1:0] = 2'($urandom % 4);
      end
      repeat (300) @(negedge clk);
      chk_ge("R6 ch0 min pulse width", g_mon[0].wmin, hp0);
      chk_ge("R6 ch1 min pulse width", g_mon[1].wmin, hp1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule